// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block models a single-clock synchronous SRAM. It accepts one command on every enabled clock edge, a read or a write in any order, and it never needs an idle cycle when the stream switches between reading and writing. The block registers the address, the three chip selects, the write enable and the per-lane byte selects on the rising edge. Read data appears at the output within the cycle that follows the edge that captured the read. The block has no output register on the read path.

Write data arrives one enabled cycle after its command. Until then, the write's address and lane mask wait in a pending register. When the data is sampled, the whole write moves into a posted-write register, and the block commits it to the array at the next enabled edge. A read that targets a posted write which is not yet committed takes the affected lanes from the posted register. Lanes that the write does not touch come from the array.

A clock-enable input freezes the whole block. The data-valid output `driveEn` stands for the tri-state control of a shared data bus. It is gated by an asynchronous output enable, and it stays low whenever the bus carries write data.

Top module: `ztSram`

## Requirements
- R1: While reset is low, and after it is released with no read issued, `driveEn` is 0 and no write is pending.
- R2: The device is selected only when `chipSelN0`=0, `chipSel1`=1 and `chipSelN2`=0. An edge with any other select combination stores nothing, and in the following cycle `driveEn` is 0.
- R3: A read is a selected command with `writeEn`=0. A read captured at an enabled edge drives the addressed word on `rdData` with `driveEn`=1 in the cycle right after that edge, provided `outEn`=1.
- R4: A write is a selected command with `writeEn`=1. Its data is sampled from `wrData` at the next enabled edge. Only the lanes whose `byteSel[i]` is 1 are changed, where lane i is bits `i*9+8 : i*9`.
- R5: A read issued directly after a write to the same address returns the write's selected lanes and the older contents in the remaining lanes.
- R6: Any mix of reads and writes on consecutive enabled edges yields correct data with no wait states.
- R7: An edge with `clkEn`=0 changes no state. `rdData` and `driveEn` hold their values, and `wrData` presented at such an edge is ignored.
- R8: `driveEn` is 0 in the cycle after a captured write, which is its data phase. `driveEn` also follows `outEn` at once, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Clock qualifier; 0 stalls the block |
| addr | input | 6 | Word address of the command |
| chipSelN0 | input | 1 | Chip select, active low |
| chipSel1 | input | 1 | Chip select, active high |
| chipSelN2 | input | 1 | Chip select, active low |
| writeEn | input | 1 | 1 = write command, 0 = read command |
| byteSel | input | 4 | Per-lane write select, active high |
| wrData | input | 36 | Write data, one enabled cycle after its command |
| outEn | input | 1 | Asynchronous output enable, active high |
| rdData | output | 36 | Flow-through read data |
| driveEn | output | 1 | Read data is valid and driven onto the bus |

## Verification
The assertions check on every cycle the drive rules: `driveEn` stays low after a write or a deselect, and it rises after a read. They also check that a stall freezes the control state and the read output, and that a pending write moves into the posted register at the next enabled edge. Two things only the bench scenarios can show: that the data values are right after lane-masked writes, and that a read is forwarded correctly from a posted write which is not yet committed. The bench compares these against an associative reference memory while the stream mixes random commands, stalls and output-enable changes.

// File: rtl/ztSramPkg.sv
package ztSramPkg;
  parameter int ADDR_W = 6;
  parameter int LANES  = 4;
  parameter int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic              step;      // enabled clock edge
    logic              loadPost;  // a write's data is due at this edge
    logic [ADDR_W-1:0] postAddr;
    logic [LANES-1:0]  postMask;
    logic [ADDR_W-1:0] rdAddr;
  } ctlStrobes_t;
endpackage

// File: rtl/ztSramCtrl.sv
module ztSramCtrl
  import ztSramPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chipSelN0,
  input  logic              chipSel1,
  input  logic              chipSelN2,
  input  logic              writeEn,
  input  logic [LANES-1:0]  byteSel,
  input  logic              outEn,
  output ctlStrobes_t       strobes,
  output logic              driveEn
);
  logic              selected;
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [LANES-1:0]  pendMask;
  logic              rdActQ;
  logic [ADDR_W-1:0] rdAddrQ;

  assign selected = !chipSelN0 && chipSel1 && !chipSelN2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendMask  <= '0;
      rdActQ    <= 1'b0;
      rdAddrQ   <= '0;
    end else if (clkEn) begin
      pendValid <= selected && writeEn;
      rdActQ    <= selected && !writeEn;
      if (selected && writeEn) begin
        pendAddr <= addr;
        pendMask <= byteSel;
      end
      if (selected && !writeEn) rdAddrQ <= addr;
    end
  end

  always_comb begin
    strobes.step     = clkEn;
    strobes.loadPost = pendValid;
    strobes.postAddr = pendAddr;
    strobes.postMask = pendMask;
    strobes.rdAddr   = rdAddrQ;
  end

  assign driveEn = outEn && rdActQ;

  // R8
  wr_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && selected && writeEn |=> !driveEn);
  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && !selected |=> !driveEn);
  // R3
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && selected && !writeEn |=> driveEn || !outEn);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(rdActQ) && $stable(pendValid) && $stable(rdAddrQ));
endmodule

// File: rtl/ztSramData.sv
module ztSramData
  import ztSramPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic              postValid;
  logic [ADDR_W-1:0] postAddr;
  logic [LANES-1:0]  postMask;
  logic [DATA_W-1:0] postData;

  // Posted-write register: holds sampled data until the next enabled edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      postValid <= 1'b0;
      postAddr  <= '0;
      postMask  <= '0;
      postData  <= '0;
    end else if (strobes.step) begin
      postValid <= strobes.loadPost;
      postAddr  <= strobes.postAddr;
      postMask  <= strobes.postMask;
      postData  <= wrData;
    end
  end

  // One storage column per lane; forwarding decided per lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic              hit;

    always_ff @(posedge clk) begin
      if (strobes.step && postValid && postMask[g])
        laneMem[postAddr] <= postData[g*LANE_W +: LANE_W];
    end

    assign hit = postValid && postMask[g] && (postAddr == strobes.rdAddr);
    assign rdData[g*LANE_W +: LANE_W] =
      hit ? postData[g*LANE_W +: LANE_W] : laneMem[strobes.rdAddr];
  end

  // R4
  post_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step && strobes.loadPost |=> postValid && postAddr == $past(strobes.postAddr));
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.step |=> $stable(rdData));
endmodule

// File: rtl/ztSram.sv
module ztSram
  import ztSramPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chipSelN0,
  input  logic              chipSel1,
  input  logic              chipSelN2,
  input  logic              writeEn,
  input  logic [LANES-1:0]  byteSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEn,
  output logic [DATA_W-1:0] rdData,
  output logic              driveEn
);
  ctlStrobes_t strobes;

  ztSramCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addr(addr),
    .chipSelN0(chipSelN0), .chipSel1(chipSel1), .chipSelN2(chipSelN2),
    .writeEn(writeEn), .byteSel(byteSel), .outEn(outEn),
    .strobes(strobes), .driveEn(driveEn)
  );

  ztSramData i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/test_ztSram.sv
`timescale 1ns/1ps
module test_ztSram;
  import ztSramPkg::*;

  logic              clk = 1'b0;
  logic              rstN, clkEn, chipSelN0, chipSel1, chipSelN2, writeEn, outEn;
  logic [ADDR_W-1:0] addr;
  logic [LANES-1:0]  byteSel;
  logic [DATA_W-1:0] wrData, rdData;
  logic              driveEn;

  always #2 clk = ~clk;  // 250 MHz

  ztSram i_ztSram (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addr(addr),
    .chipSelN0(chipSelN0), .chipSel1(chipSel1), .chipSelN2(chipSelN2),
    .writeEn(writeEn), .byteSel(byteSel), .wrData(wrData), .outEn(outEn),
    .rdData(rdData), .driveEn(driveEn)
  );

  int checks = 0;
  int errors = 0;
  int deselCnt = 0;

  // Behavioural reference
  logic [DATA_W-1:0] refMem [int];
  bit                pendV = 0;
  int                pendA;
  logic [LANES-1:0]  pendM;
  bit                expDrive = 0;
  logic [DATA_W-1:0] expData = '0;

  function automatic logic [DATA_W-1:0] pattern(int a);
    return {4'ha, 16'(a * 977), 16'(a ^ 16'h5a5a)};
  endfunction

  task automatic chk(bit ok, string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic en, input logic s, input logic we, input int a,
                      input logic [LANES-1:0] m, input logic [DATA_W-1:0] d,
                      input logic oe, input string tag);
    logic [DATA_W-1:0] w;
    clkEn = en; writeEn = we; addr = ADDR_W'(a); byteSel = m; wrData = d; outEn = oe;
    if (s) {chipSelN0, chipSel1, chipSelN2} = 3'b010;
    else begin
      case (deselCnt % 3)
        0: {chipSelN0, chipSel1, chipSelN2} = 3'b110;
        1: {chipSelN0, chipSel1, chipSelN2} = 3'b000;
        default: {chipSelN0, chipSel1, chipSelN2} = 3'b011;
      endcase
      deselCnt++;
    end
    @(posedge clk);
    if (en) begin
      if (pendV) begin
        w = refMem.exists(pendA) ? refMem[pendA] : '0;
        for (int l = 0; l < LANES; l++)
          if (pendM[l]) w[l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
        refMem[pendA] = w;
      end
      pendV = s && we; pendA = a; pendM = m;
      expDrive = s && !we;
      if (expDrive) expData = refMem.exists(a) ? refMem[a] : '0;
    end
    @(negedge clk);
    chk(driveEn == (expDrive && oe), tag, DATA_W'(driveEn), DATA_W'(expDrive && oe));
    if (expDrive && oe) chk(rdData == expData, tag, rdData, expData);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; clkEn = 1'b1; writeEn = 1'b0; addr = '0; byteSel = '0;
    wrData = '0; outEn = 1'b1; {chipSelN0, chipSel1, chipSelN2} = 3'b010;
    repeat (3) @(negedge clk);
    chk(driveEn == 1'b0, "R1", DATA_W'(driveEn), '0);
    rstN = 1'b1;
    tick(1, 0, 0, 0, '0, '0, 1, "R1");

    // Fill every word back to back
    for (int a = 0; a < DEPTH; a++)
      tick(1, 1, 1, a, '1, (a == 0) ? '0 : pattern(a - 1), 1, "R6");
    tick(1, 0, 0, 0, '0, pattern(DEPTH - 1), 1, "R2");

    // Plain flow-through read
    tick(1, 1, 0, 5, '0, '0, 1, "R3");
    chk(rdData == pattern(5), "R3", rdData, pattern(5));

    // Lane-masked write, lanes 0 and 2
    tick(1, 1, 1, 7, 4'b0101, '0, 1, "R4");
    tick(1, 0, 0, 0, '0, 36'h123456789, 1, "R4");
    tick(1, 1, 0, 7, '0, '0, 1, "R4");

    // Deselected write leaves the word alone
    tick(1, 0, 1, 3, '1, '0, 1, "R2");
    tick(1, 0, 0, 0, '0, '1, 1, "R2");
    tick(1, 1, 0, 3, '0, '0, 1, "R2");
    chk(rdData == pattern(3), "R2", rdData, pattern(3));

    // Read right after write: forwarding from posted register
    tick(1, 1, 1, 9, 4'b0011, '0, 1, "R5");
    tick(1, 1, 0, 9, '0, 36'habcde1234, 1, "R5");
    tick(1, 1, 0, 9, '0, '0, 1, "R5");

    // Stalls: garbage data ignored, output held
    tick(1, 1, 1, 11, '1, '0, 1, "R7");
    tick(0, 1, 0, 2, '1, '1, 1, "R7");
    tick(0, 0, 1, 4, '1, 36'h555555555, 1, "R7");
    tick(1, 1, 0, 11, '0, 36'h0f0f0f0f0, 1, "R7");
    tick(0, 1, 1, 1, '1, '1, 1, "R7");
    tick(0, 1, 1, 1, '1, '1, 1, "R7");
    tick(1, 0, 0, 0, '0, '0, 1, "R7");

    // Drive control
    tick(1, 1, 0, 5, '0, '0, 0, "R8");
    outEn = 1'b1; #0.5;
    chk(driveEn == 1'b1, "R8", DATA_W'(driveEn), 1);
    tick(1, 1, 1, 12, '1, '0, 1, "R8");
    tick(1, 0, 0, 0, '0, 36'h777777777, 1, "R8");

    // Random mixed stream with stalls
    for (int i = 0; i < 3000; i++)
      tick($urandom_range(0, 9) < 8, $urandom_range(0, 15) != 0, 1'($urandom_range(0, 1)),
           $urandom_range(0, 15), LANES'($urandom()), DATA_W'({$urandom(), $urandom()}),
           $urandom_range(0, 9) != 0, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule